// File: doc/BRIEF.md
# Internal Data Memory Router

This block sits between an 8-bit core's operand logic and its 256-byte internal scratch RAM. It takes one access request per clock and decides where that request goes: a RAM byte, the special-function-register (SFR) port, or one of two registers that the block owns itself. These are the stack pointer and the two working-bank select bits.

The upper half of the byte address range has two meanings. The addressing mode, not the address, decides which one applies. Direct accesses above 7Fh reach SFRs, while indirect accesses and stack traffic reach upper RAM.

Register operands are relocated into one of four eight-byte banks. A 256-entry bit address space is folded onto a sixteen-byte RAM window and onto the SFRs whose addresses end in 0 or 8. A bit write reads the containing byte, replaces one bit and writes the byte back within the same clock. Reads and pops answer one cycle later on a registered response.

Top module: `idata_router`

## Requirements
- R1: A direct access (mode 00) at an address below 80h reaches the RAM byte at that address. At 80h or above, it raises `sfr_sel` with `sfr_addr` equal to the address and `sfr_we` high only for a write (op 01). The read op is 00.
- R2: An indirect access (mode 01) reaches the RAM byte at the given address for every address, including 80h–FFh, and never raises `sfr_sel`.
- R3: A register access (mode 10) reaches RAM byte {bank[1:0], addr[2:0]}; address bits 7..3 are ignored.
- R4: The bank register answers direct address D0h with the bank in bits 4:3 and zeros elsewhere. It resets to bank 0. It is written by a direct byte write (bits 4:3 taken) or by bit writes to bit addresses D3h and D4h.
- R5: A bit access (mode 11) to bit address 00h–7Fh targets RAM byte 20h + addr[6:3], bit addr[2:0]. A bit read returns the bit in `rsp_rdata[0]`, with the other bits zero.
- R6: A bit access to bit address 80h–FFh targets the SFR at addr & F8h. A bit write drives `sfr_wdata` as the current `sfr_rdata` with bit addr[2:0] replaced by `req_wdata[0]`, in the same cycle as `sfr_we`.
- R7: A bit write to RAM changes only the addressed bit of its byte.
- R8: The stack pointer answers direct address 81h, resets to 07h, and can be read and written there. Accesses to 81h and D0h never raise `sfr_sel`.
- R9: A push (op 10) increments the stack pointer with wrap from FFh to 00h, then writes `req_wdata` to RAM at the new value.
- R10: A pop (op 11) returns the RAM byte at the stack pointer, then decrements it with wrap from 00h to FFh.
- R11: `rsp_valid` is high in the cycle after an accepted read or pop, carrying its data in `rsp_rdata`, and is low after writes, pushes, idle cycles and during reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_mode | input | 2 | 00 direct, 01 indirect, 10 register, 11 bit |
| req_op | input | 2 | 00 read, 01 write, 10 push, 11 pop |
| req_addr | input | 8 | Byte, register or bit address |
| req_wdata | input | 8 | Write data; bit 0 is the value for bit writes |
| rsp_valid | output | 1 | Read or pop data valid |
| rsp_rdata | output | 8 | Read or pop data |
| sfr_sel | output | 1 | External SFR access this cycle |
| sfr_we | output | 1 | External SFR write strobe |
| sfr_addr | output | 8 | External SFR address |
| sfr_wdata | output | 8 | External SFR write data |
| sfr_rdata | input | 8 | External SFR read data, combinational |

## Verification
A bit write does its read of the target byte and its write-back in the same cycle. A change of bank or stack pointer also takes effect right before the next access that depends on it. The bench provokes both by sending requests back to back with no idle cycle. It issues consecutive bit writes into one RAM byte and bit writes into an SFR. It changes the bank and then immediately uses a register operand. It writes the stack pointer and then immediately pushes or pops. A behavioural model of RAM, stack pointer and bank is checked against the SFR port in every request cycle and against the response on the following clock.

// File: rtl/idr_pkg.sv
package idr_pkg;
  typedef enum logic [1:0] {
    AM_DIRECT   = 2'b00,
    AM_INDIRECT = 2'b01,
    AM_REGISTER = 2'b10,
    AM_BIT      = 2'b11
  } amode_e;

  typedef enum logic [1:0] {
    OP_READ  = 2'b00,
    OP_WRITE = 2'b01,
    OP_PUSH  = 2'b10,
    OP_POP   = 2'b11
  } aop_e;

  typedef struct packed {
    logic       to_sfr;
    logic       is_bit;
    logic [7:0] byte_addr;
    logic [2:0] bit_idx;
  } route_t;
endpackage

// File: rtl/idr_resolve.sv
module idr_resolve
  import idr_pkg::*;
#(
  parameter logic [7:0] BIT_BASE = 8'h20
) (
  input  amode_e     mode,
  input  aop_e       op,
  input  logic [7:0] addr,
  input  logic [1:0] bank,
  input  logic [7:0] sp,
  output route_t     route
);
  always_comb begin
    route = '0;
    case (op)
      OP_PUSH: route.byte_addr = sp + 8'd1;
      OP_POP:  route.byte_addr = sp;
      default: begin
        case (mode)
          AM_DIRECT: begin
            route.byte_addr = addr;
            route.to_sfr    = addr[7];
          end
          AM_INDIRECT: route.byte_addr = addr;
          AM_REGISTER: route.byte_addr = {3'b000, bank, addr[2:0]};
          default: begin
            route.is_bit  = 1'b1;
            route.bit_idx = addr[2:0];
            if (addr[7]) begin
              route.to_sfr    = 1'b1;
              route.byte_addr = {addr[7:3], 3'b000};
            end else begin
              route.byte_addr = BIT_BASE + {4'b0000, addr[6:3]};
            end
          end
        endcase
      end
    endcase
  end
endmodule

// File: rtl/idr_ctrl_regs.sv
module idr_ctrl_regs #(
  parameter logic [7:0] SP_INIT = 8'h07
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       inc,
  input  logic       dec,
  input  logic       sp_we,
  input  logic [7:0] sp_d,
  input  logic       bank_we,
  input  logic [1:0] bank_d,
  output logic [7:0] sp_q,
  output logic [1:0] bank_q
);
  logic [7:0] sp_n;
  logic       sp_en;

  always_comb begin
    sp_en = sp_we | inc | dec;
    sp_n  = sp_q;
    if (sp_we)    sp_n = sp_d;
    else if (inc) sp_n = sp_q + 8'd1;
    else if (dec) sp_n = sp_q - 8'd1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     sp_q <= SP_INIT;
    else if (sp_en) sp_q <= sp_n;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       bank_q <= 2'b00;
    else if (bank_we) bank_q <= bank_d;
  end

  // R9
  push_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !sp_we) |=> (sp_q == $past(sp_q) + 8'd1));

  // R10
  pop_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !sp_we) |=> (sp_q == $past(sp_q) - 8'd1));

  // R4
  bank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bank_we |=> $stable(bank_q));
endmodule

// File: rtl/idr_ram.sv
module idr_ram #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/idata_router.sv
module idata_router
  import idr_pkg::*;
#(
  parameter logic [7:0] SP_SFR   = 8'h81,
  parameter logic [7:0] BANK_SFR = 8'hD0,
  parameter int         BANK_LSB = 3,
  parameter logic [7:0] SP_INIT  = 8'h07,
  parameter logic [7:0] BIT_BASE = 8'h20
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic [1:0] req_mode,
  input  logic [1:0] req_op,
  input  logic [7:0] req_addr,
  input  logic [7:0] req_wdata,
  output logic       rsp_valid,
  output logic [7:0] rsp_rdata,
  output logic       sfr_sel,
  output logic       sfr_we,
  output logic [7:0] sfr_addr,
  output logic [7:0] sfr_wdata,
  input  logic [7:0] sfr_rdata
);
  logic [1:0] rst_pipe;
  logic       rst_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_s = rst_pipe[1];

  amode_e     mode;
  aop_e       op;
  route_t     rt;
  logic       acc, is_wr, rd_like;
  logic       hit_sp, hit_bank, local_hit;
  logic [7:0] sp_q, bank_byte, cur_byte, new_byte, rd_val, ram_rd;
  logic [1:0] bank_q;
  logic       ram_we, sp_we, bank_we, inc, dec;
  logic       rsp_valid_n;
  logic [7:0] rsp_rdata_n;

  assign mode    = amode_e'(req_mode);
  assign op      = aop_e'(req_op);
  assign acc     = req_valid & rst_s;
  assign is_wr   = (op == OP_WRITE);
  assign rd_like = (op == OP_READ) || (op == OP_POP);

  idr_resolve #(.BIT_BASE(BIT_BASE)) u_resolve (
    .mode(mode), .op(op), .addr(req_addr), .bank(bank_q), .sp(sp_q), .route(rt)
  );

  idr_ram #(.AW(8), .DW(8)) u_ram (
    .clk(clk), .we(ram_we), .waddr(rt.byte_addr), .wdata(new_byte),
    .raddr(rt.byte_addr), .rdata(ram_rd)
  );

  idr_ctrl_regs #(.SP_INIT(SP_INIT)) u_ctrl (
    .clk(clk), .rst_n(rst_s), .inc(inc), .dec(dec),
    .sp_we(sp_we), .sp_d(new_byte),
    .bank_we(bank_we), .bank_d(new_byte[BANK_LSB +: 2]),
    .sp_q(sp_q), .bank_q(bank_q)
  );

  always_comb begin
    hit_sp    = rt.to_sfr && (rt.byte_addr == SP_SFR);
    hit_bank  = rt.to_sfr && (rt.byte_addr == BANK_SFR);
    local_hit = hit_sp | hit_bank;
    bank_byte = '0;
    bank_byte[BANK_LSB +: 2] = bank_q;
    if (hit_sp)        cur_byte = sp_q;
    else if (hit_bank) cur_byte = bank_byte;
    else if (rt.to_sfr) cur_byte = sfr_rdata;
    else               cur_byte = ram_rd;
    new_byte = req_wdata;
    rd_val   = cur_byte;
    if (rt.is_bit) begin
      new_byte             = cur_byte;
      new_byte[rt.bit_idx] = req_wdata[0];
      rd_val               = {7'b0000000, cur_byte[rt.bit_idx]};
    end
  end

  assign ram_we    = acc && !rt.to_sfr && (is_wr || (op == OP_PUSH));
  assign sfr_sel   = acc && rt.to_sfr && !local_hit;
  assign sfr_we    = sfr_sel && is_wr;
  assign sfr_addr  = rt.byte_addr;
  assign sfr_wdata = new_byte;
  assign inc       = acc && (op == OP_PUSH);
  assign dec       = acc && (op == OP_POP);
  assign sp_we     = acc && is_wr && hit_sp;
  assign bank_we   = acc && is_wr && hit_bank;

  always_comb begin
    rsp_valid_n = acc && rd_like;
    rsp_rdata_n = rd_val;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) rsp_valid <= 1'b0;
    else        rsp_valid <= rsp_valid_n;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s)           rsp_rdata <= '0;
    else if (rsp_valid_n) rsp_rdata <= rsp_rdata_n;
  end

  // R2
  indirect_ram_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (acc && mode == AM_INDIRECT && !op[1]) |-> !sfr_sel);

  // R3
  reg_window_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (acc && mode == AM_REGISTER && !op[1]) |-> (!sfr_sel && rt.byte_addr[7:5] == 3'b000));

  // R5
  bit_window_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (acc && mode == AM_BIT && !op[1] && !req_addr[7]) |-> (rt.byte_addr[7:4] == BIT_BASE[7:4]));

  // R1
  one_target_chk: assert property (@(posedge clk) disable iff (!rst_s)
    $onehot0({sfr_sel, ram_we, sp_we, bank_we}));

  // R11
  no_rsp_chk: assert property (@(posedge clk) disable iff (!rst_s)
    !(acc && rd_like) |=> !rsp_valid);
endmodule

// File: tb/idata_router_bench.sv
`timescale 1ns/1ps
module idata_router_bench;
  localparam logic [1:0] M_DIR = 2'b00, M_IND = 2'b01, M_REG = 2'b10, M_BIT = 2'b11;
  localparam logic [1:0] O_RD = 2'b00, O_WR = 2'b01, O_PUSH = 2'b10, O_POP = 2'b11;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic       rst_n, req_valid;
  logic [1:0] req_mode, req_op;
  logic [7:0] req_addr, req_wdata;
  logic       rsp_valid, sfr_sel, sfr_we;
  logic [7:0] rsp_rdata, sfr_addr, sfr_wdata, sfr_rdata;

  logic [7:0] sfr_mem [128];
  logic [7:0] ram_m [256];
  int sp_m, bank_m;
  int tests = 0, fails = 0;
  bit done = 0;

  idata_router u_idata_router (.*);

  assign sfr_rdata = sfr_mem[sfr_addr[6:0]];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 128; i++) sfr_mem[i] <= 8'(i) ^ 8'hC3;
    end else if (sfr_sel && sfr_we) begin
      sfr_mem[sfr_addr[6:0]] <= sfr_wdata;
    end
  end

  task automatic chk(input string rq, input string what, input logic [7:0] act, input logic [7:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
    end
  endtask

  task automatic do_req(input logic [1:0] m, input logic [1:0] o, input logic [7:0] a,
                        input logic [7:0] d, input string rq);
    logic [7:0] ba, cur, nb, erd;
    logic       ext, loc, bitm, erv;
    logic [2:0] bi;
    ba = a; ext = 1'b0; loc = 1'b0; bitm = (m == M_BIT); bi = a[2:0]; erd = '0;
    erv = (o == O_RD) || (o == O_POP);
    req_valid = 1'b1; req_mode = m; req_op = o; req_addr = a; req_wdata = d;
    #1;
    if (o == O_PUSH) begin
      sp_m = (sp_m + 1) % 256;
      ram_m[sp_m] = d;
      chk(rq, "sfr_sel on push", {7'b0, sfr_sel}, 8'h00);
    end else if (o == O_POP) begin
      erd  = ram_m[sp_m];
      sp_m = (sp_m + 255) % 256;
      chk(rq, "sfr_sel on pop", {7'b0, sfr_sel}, 8'h00);
    end else begin
      case (m)
        M_DIR: ext = a[7];
        M_IND: ext = 1'b0;
        M_REG: ba = 8'(bank_m * 8 + a % 8);
        default: begin
          if (a < 8'h80) ba = 8'(32 + a / 8);
          else begin ext = 1'b1; ba = a & 8'hF8; end
        end
      endcase
      loc = ext && (ba == 8'h81 || ba == 8'hD0);
      if (loc) cur = (ba == 8'h81) ? 8'(sp_m) : 8'(bank_m * 8);
      else if (ext) cur = sfr_mem[ba[6:0]];
      else cur = ram_m[ba];
      nb = d;
      if (bitm) begin nb = cur; nb[bi] = d[0]; erd = {7'b0, cur[bi]}; end
      else erd = cur;
      chk(rq, "sfr_sel", {7'b0, sfr_sel}, {7'b0, ext && !loc});
      if (ext && !loc) begin
        chk(rq, "sfr_addr", sfr_addr, ba);
        chk(rq, "sfr_we", {7'b0, sfr_we}, {7'b0, o == O_WR});
        if (o == O_WR) chk(rq, "sfr_wdata", sfr_wdata, nb);
      end
      if (o == O_WR) begin
        if (loc) begin
          if (ba == 8'h81) sp_m = nb;
          else bank_m = (nb >> 3) & 3;
        end else if (!ext) ram_m[ba] = nb;
      end
    end
    @(negedge clk);
    chk(rq, "rsp_valid", {7'b0, rsp_valid}, {7'b0, erv});
    if (erv) chk(rq, "rsp_rdata", rsp_rdata, erd);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_mode = '0; req_op = '0; req_addr = '0; req_wdata = '0;
    sp_m = 7; bank_m = 0;
    repeat (3) @(negedge clk);
    chk("R11", "rsp_valid in reset", {7'b0, rsp_valid}, 8'h00);
    chk("R1", "sfr_sel in reset", {7'b0, sfr_sel}, 8'h00);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R8 R4 reset values
    do_req(M_DIR, O_RD, 8'h81, 8'h00, "R8");
    do_req(M_DIR, O_RD, 8'hD0, 8'h00, "R4");
    // R2 fill every byte, upper half included
    for (int i = 0; i < 256; i++) do_req(M_IND, O_WR, 8'(i), 8'(i) ^ 8'h5A, "R2");
    // R1 / R2 split of the upper half
    do_req(M_DIR, O_RD, 8'h35, 8'h00, "R1");
    do_req(M_IND, O_RD, 8'h9C, 8'h00, "R2");
    do_req(M_DIR, O_RD, 8'h9C, 8'h00, "R1");
    do_req(M_DIR, O_WR, 8'hA5, 8'h3C, "R1");
    do_req(M_DIR, O_RD, 8'hA5, 8'h00, "R1");
    do_req(M_IND, O_RD, 8'hA5, 8'h00, "R2");
    do_req(M_IND, O_WR, 8'hD0, 8'hFF, "R2");
    do_req(M_DIR, O_RD, 8'hD0, 8'h00, "R4");
    // R3 / R4 bank relocation, back to back
    do_req(M_REG, O_RD, 8'h05, 8'h00, "R3");
    do_req(M_DIR, O_WR, 8'hD0, 8'hFF, "R4");
    do_req(M_REG, O_RD, 8'hF5, 8'h00, "R3");
    do_req(M_DIR, O_RD, 8'hD0, 8'h00, "R4");
    do_req(M_REG, O_WR, 8'h02, 8'h77, "R3");
    do_req(M_IND, O_RD, 8'h1A, 8'h00, "R3");
    do_req(M_BIT, O_WR, 8'hD4, 8'h00, "R4");
    do_req(M_BIT, O_RD, 8'hD3, 8'h00, "R4");
    do_req(M_REG, O_RD, 8'h00, 8'h00, "R3");
    // R5 / R7 RAM bit window, consecutive writes to one byte
    do_req(M_BIT, O_WR, 8'h12, 8'h01, "R7");
    do_req(M_BIT, O_WR, 8'h17, 8'h00, "R7");
    do_req(M_BIT, O_WR, 8'h10, 8'hFF, "R7");
    do_req(M_IND, O_RD, 8'h22, 8'h00, "R7");
    do_req(M_BIT, O_RD, 8'h12, 8'h00, "R5");
    do_req(M_BIT, O_RD, 8'h7F, 8'h00, "R5");
    do_req(M_BIT, O_RD, 8'h00, 8'h00, "R5");
    // R6 SFR bit read-modify-write
    do_req(M_BIT, O_RD, 8'h93, 8'h00, "R6");
    do_req(M_BIT, O_WR, 8'h93, 8'h01, "R6");
    do_req(M_BIT, O_WR, 8'h96, 8'h00, "R6");
    do_req(M_DIR, O_RD, 8'h90, 8'h00, "R6");
    do_req(M_BIT, O_WR, 8'hFF, 8'h00, "R6");
    // R8 / R9 / R10 stack with wrap
    do_req(M_DIR, O_WR, 8'h81, 8'hFE, "R8");
    do_req(M_DIR, O_PUSH, 8'h00, 8'hA1, "R9");
    do_req(M_DIR, O_PUSH, 8'h00, 8'hB2, "R9");
    do_req(M_DIR, O_RD, 8'h81, 8'h00, "R9");
    do_req(M_DIR, O_POP, 8'h00, 8'h00, "R10");
    do_req(M_DIR, O_POP, 8'h00, 8'h00, "R10");
    do_req(M_DIR, O_RD, 8'h81, 8'h00, "R8");
    do_req(M_DIR, O_WR, 8'h81, 8'h00, "R8");
    do_req(M_DIR, O_POP, 8'h00, 8'h00, "R10");
    do_req(M_DIR, O_RD, 8'h81, 8'h00, "R10");
    do_req(M_DIR, O_PUSH, 8'h00, 8'h6E, "R9");
    do_req(M_DIR, O_POP, 8'h00, 8'h00, "R10");
    // R11 idle cycle
    req_valid = 1'b0;
    @(negedge clk);
    chk("R11", "rsp_valid idle", {7'b0, rsp_valid}, 8'h00);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule